// File: doc/BRIEF.md
# Coherency Exit Link Controller

This block steps a requester node into and out of the coherency domain and drives the transmit side of its link while it does so. A local join request starts entry. The block raises its coherency request and waits for the interconnect acknowledge, which arrives asynchronously and passes through a synchronizer. When the local request falls, the block drops its coherency request. It keeps the transmit link-active request high until the synchronized acknowledge also falls, because snoops can still be in flight. It then emits a one-cycle exit-complete pulse.

The transmit activity output is high whenever the coherency request is high. It also stays high while the node is anywhere in the handshake, and while a pending-traffic flag is set. The pending-traffic flag counts only after the node has asked for coherency at least once since reset. This keeps transmit activity from rising before the first coherency request. Every output comes from a register. None of the outputs can show activity or a completed exit in the cycles that follow reset.

Top module: `coh_link_ctrl`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high, every output is 0 at the next clock and the controller returns to the idle (out of coherency) state.
- R2: Whenever `coh_req_o` is 1, `tx_active_o` is also 1.
- R3: After reset, `tx_active_o` stays 0 until the first cycle in which `coh_req_o` is 1, even if `pending_i` is 1.
- R4: `exit_done_o` is 0 in the first cycle after reset is released.
- R5: After `join_i` falls in the joined state, `coh_req_o` drops at the next clock. `link_active_o` stays 1 for as long as the synchronized acknowledge is still 1.
- R6: `exit_done_o` is a single-cycle pulse. It appears only in the cycle in which the controller leaves the exiting phase because the synchronized acknowledge is 0, and `link_active_o` is 0 in that same cycle.
- R7: `ack_i` passes through two register stages before the controller uses it. A change on `ack_i` sampled at edge k therefore affects the outputs after edge k+2.
- R8: Once `coh_req_o` has been 1 since reset, `tx_active_o` is 1 in every cycle after a clock that sampled `pending_i` high, whatever the state.
- R9: A `join_i` that rises again during the exiting phase has no effect until the exit completes. The controller then raises `coh_req_o` again from the idle state.
- R10: If `join_i` falls while the controller is still waiting for the first acknowledge, it returns to idle without an exit-done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| join_i | input | 1 | Local request to be in the coherency domain |
| ack_i | input | 1 | Coherency acknowledge from the interconnect (asynchronous) |
| pending_i | input | 1 | Link traffic still outstanding |
| coh_req_o | output | 1 | Coherency request to the interconnect |
| tx_active_o | output | 1 | Transmit-side activity indication |
| link_active_o | output | 1 | Transmit link-active request |
| exit_done_o | output | 1 | One-cycle pulse at the end of a coherency exit |

## Verification
The bench drives `pending_i` high during and right after reset. A design that lets pending traffic through before the first coherency request would raise transmit activity too early. The bench holds the acknowledge high for several cycles after the local request drops. A controller that released the link with the request would lose `link_active_o` in the middle of the exit. The bench also re-raises the join during an exit and aborts a join before any acknowledge. These stimuli catch a design that jumps straight back into the joined state, and one that emits a false exit pulse. Every cycle is compared against a reference model that includes the two-stage acknowledge delay, so a synchronizer that is one stage short shifts every transition and shows up as a mismatch.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ENTER = 2'd1,
    ST_JOIN  = 2'd2,
    ST_EXIT  = 2'd3
  } coh_state_e;
endpackage

// File: rtl/coh_sync.sv
module coh_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;
  logic [LAST:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[LAST-1:0], d};
      end
    end
  endgenerate

  assign q = pipe[LAST];
endmodule

// File: rtl/coh_fsm.sv
module coh_fsm
  import coh_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       join_req,
  input  logic       ack_s,
  output coh_state_e state_d,
  output logic       exit_evt
);
  coh_state_e state_q;

  always_comb begin
    state_d  = state_q;
    exit_evt = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (join_req) state_d = ST_ENTER;
      ST_ENTER: begin
        if (ack_s)          state_d = join_req ? ST_JOIN : ST_EXIT;
        else if (!join_req) state_d = ST_IDLE;
      end
      ST_JOIN:  if (!join_req) state_d = ST_EXIT;
      ST_EXIT: begin
        if (!ack_s) begin
          state_d  = ST_IDLE;
          exit_evt = 1'b1;
        end
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  AST_EXIT_HELD_BY_ACK: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_EXIT && ack_s) |=> (state_q == ST_EXIT)); // R5
  AST_REJOIN_VIA_ENTER: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_EXIT) |=> (state_q != ST_JOIN)); // R9
endmodule

// File: rtl/coh_outreg.sv
module coh_outreg
  import coh_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  coh_state_e state_d,
  input  logic       exit_evt,
  input  logic       pending,
  output logic       coh_req,
  output logic       tx_active,
  output logic       link_active,
  output logic       exit_done
);
  logic req_d, link_d, seen_q, seen_d;

  assign req_d  = (state_d == ST_ENTER) || (state_d == ST_JOIN);
  assign link_d = (state_d != ST_IDLE);
  assign seen_d = seen_q || req_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      coh_req     <= 1'b0;
      tx_active   <= 1'b0;
      link_active <= 1'b0;
      exit_done   <= 1'b0;
      seen_q      <= 1'b0;
    end else begin
      coh_req     <= req_d;
      link_active <= link_d;
      tx_active   <= link_d || (pending && seen_d);
      exit_done   <= exit_evt;
      seen_q      <= seen_d;
    end
  end

  AST_TX_AFTER_FIRST_REQ: assert property (@(posedge clk) disable iff (rst)
    tx_active |-> seen_q); // R3
endmodule

// File: rtl/coh_link_ctrl.sv
module coh_link_ctrl
  import coh_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic join_i,
  input  logic ack_i,
  input  logic pending_i,
  output logic coh_req_o,
  output logic tx_active_o,
  output logic link_active_o,
  output logic exit_done_o
);
  logic       ack_s;
  logic       exit_evt;
  coh_state_e state_d;

  coh_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(ack_i), .q(ack_s)
  );

  coh_fsm u_fsm (
    .clk(clk), .rst(rst), .join_req(join_i), .ack_s(ack_s),
    .state_d(state_d), .exit_evt(exit_evt)
  );

  coh_outreg u_out (
    .clk(clk), .rst(rst), .state_d(state_d), .exit_evt(exit_evt),
    .pending(pending_i), .coh_req(coh_req_o), .tx_active(tx_active_o),
    .link_active(link_active_o), .exit_done(exit_done_o)
  );

  AST_REQ_NEEDS_TX: assert property (@(posedge clk) disable iff (rst)
    coh_req_o |-> tx_active_o); // R2
  AST_NO_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !exit_done_o); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    exit_done_o |=> !exit_done_o); // R6
  AST_DONE_LINK_LOW: assert property (@(posedge clk) disable iff (rst)
    exit_done_o |-> !link_active_o); // R6
  AST_LINK_KEPT: assert property (@(posedge clk) disable iff (rst)
    (link_active_o && !coh_req_o && ack_s) |=> link_active_o); // R5
endmodule

// File: tb/tb_coh_link_ctrl.sv
module tb_coh_link_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst, join_i, ack_i, pending_i;
  logic coh_req_o, tx_active_o, link_active_o, exit_done_o;

  int n_cmp = 0;
  int n_bad = 0;
  string tag = "R1";

  // reference model state: 0 idle, 1 entering, 2 joined, 3 exiting
  int m_st = 0;
  bit m_a1, m_a2, m_seen;
  bit e_req, e_tx, e_link, e_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  coh_link_ctrl dut (
    .clk(clk), .rst(rst), .join_i(join_i), .ack_i(ack_i),
    .pending_i(pending_i), .coh_req_o(coh_req_o), .tx_active_o(tx_active_o),
    .link_active_o(link_active_o), .exit_done_o(exit_done_o)
  );

  task automatic model_step();
    bit a_use;
    int nx;
    if (rst) begin
      m_st = 0; m_a1 = 0; m_a2 = 0; m_seen = 0;
      e_req = 0; e_tx = 0; e_link = 0; e_done = 0;
    end else begin
      a_use = m_a2;
      m_a2 = m_a1;
      m_a1 = ack_i;
      nx = m_st;
      e_done = 0;
      case (m_st)
        0: if (join_i) nx = 1;
        1: if (a_use) nx = join_i ? 2 : 3; else if (!join_i) nx = 0;
        2: if (!join_i) nx = 3;
        default: if (!a_use) begin nx = 0; e_done = 1; end
      endcase
      m_st = nx;
      e_req = (nx == 1) || (nx == 2);
      e_link = (nx != 0);
      m_seen = m_seen || e_req;
      e_tx = e_link || (pending_i && m_seen);
    end
  endtask

  task automatic chk(string nm, logic act, bit exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at %0t: actual %b expected %b", tag, nm, $time, act, exp);
    end
  endtask

  task automatic cyc(bit r, bit j, bit a, bit p);
    rst = r; join_i = j; ack_i = a; pending_i = p;
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk("coh_req_o", coh_req_o, e_req);
    chk("tx_active_o", tx_active_o, e_tx);
    chk("link_active_o", link_active_o, e_link);
    chk("exit_done_o", exit_done_o, e_done);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tag = "R1";                          // reset with every input high
    for (int i = 0; i < 4; i++) cyc(1, 1, 1, 1);
    tag = "R4";                          // first cycle out of reset
    cyc(0, 0, 1, 1);
    tag = "R3";                          // pending before any request
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 1);
    tag = "R2";                          // entry, waiting on the acknowledge
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, i[0]);
    tag = "R7";                          // acknowledge crosses two stages
    for (int i = 0; i < 4; i++) cyc(0, 1, 1, 0);
    tag = "R5";                          // exit with the acknowledge still high
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 0);
    tag = "R6";                          // acknowledge falls, done pulse
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0);
    tag = "R8";                          // pending after the first request
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, i < 2);
    tag = "R9";                          // rejoin during exit
    for (int i = 0; i < 5; i++) cyc(0, 1, 1, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0);
    for (int i = 0; i < 3; i++) cyc(0, 1, 1, 0);
    for (int i = 0; i < 6; i++) cyc(0, 1, 0, 0);
    for (int i = 0; i < 4; i++) cyc(0, 1, 1, 0);
    tag = "R10";                         // abort before any acknowledge
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0);
    cyc(0, 1, 0, 0);
    cyc(0, 1, 0, 0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0);
    tag = "R1";                          // reset from the middle of a join
    for (int i = 0; i < 4; i++) cyc(0, 1, 1, 0);
    for (int i = 0; i < 2; i++) cyc(1, 1, 1, 1);
    tag = "R4";
    cyc(0, 0, 0, 1);
    tag = "R3";
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1);
    finish_run();
  end
endmodule